// File: doc/BRIEF.md
# Daisy-Chained Byte Capture Stage

This block is one stage of a receive chain in which several identical stages listen to the same stream of decoded bytes and frame-start markers, all in the same clock cycle. Each stage keeps exactly one byte of a multi-byte frame. Which byte a stage keeps is decided by a handshake with its neighbours, not by a shared counter. A stage may take a byte only while its catch-enable input is high. Once it has taken its byte, it raises a taken flag that becomes the catch-enable of the next stage down the chain.

The first stage has its catch-enable tied high, so it keeps the first byte that follows a frame-start marker. The second stage keeps the byte after that, and so on. A wider frame needs only more stages, each wired to the flag of the one before it. The taken flag of the last stage is left open. Every stage shows the byte it captured on a registered parallel output and pulses a one-cycle valid strobe when that byte arrives.

Top module: `byte_chain_stage`

## Requirements
- R1: A synchronous active-high reset clears the taken flag, the data output and the valid strobe to zero.
- R2: On a cycle where the byte-valid input is high, the frame-start input is low, catch-enable is high and the taken flag is low, the stage captures the byte. On the next cycle the data output equals that byte, the valid strobe is high and the taken flag is high.
- R3: While catch-enable is low, no byte is captured and the valid strobe stays low.
- R4: Once its taken flag is high, a stage captures nothing more until the next frame-start marker. Further bytes leave the valid strobe low and the data output unchanged.
- R5: A frame-start cycle clears the taken flag on the following cycle. A byte presented in the same cycle as a frame-start marker is never captured.
- R6: The valid strobe is high for exactly one cycle per capture.
- R7: In a chain whose first catch-enable is held high, stage k (counting from 0) captures the (k+1)-th byte after a frame-start marker. This holds when bytes arrive on consecutive cycles and when idle cycles separate them.
- R8: Between captures, the data output holds the last captured byte, including across frame-start markers.
- R9: The taken flag rises only on a cycle in which the valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded byte is present on in_byte this cycle |
| in_sync | input | 1 | Frame-start marker observed this cycle |
| in_byte | input | DATA_W | Shared decoded byte |
| catch_en | input | 1 | Permission from upstream neighbour (tied high on the first stage) |
| taken | output | 1 | This stage holds its byte for the current frame; feeds the next stage |
| out_byte | output | DATA_W | Last captured byte |
| out_valid | output | 1 | One-cycle strobe when out_byte is updated |

## Verification
The hardest case to reach is a frame-start marker placed directly after the last byte of a frame, followed at once by the next frame's bytes. During the marker cycle every downstream stage still sees a stale high catch-enable left from the previous frame. The bench creates this case by driving frames back to back with no idle cycles, and also by asserting byte-valid together with the marker. A scoreboard then confirms that no stage takes a byte early or takes a byte twice. Frames shorter and longer than the chain, and a first-stage enable that is dropped and then raised mid-frame, cover the remaining orderings.

// File: rtl/byte_chain_pkg.sv
package byte_chain_pkg;

  // Per-frame occupancy of one stage
  typedef enum logic [0:0] {
    SLOT_OPEN = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_t;

endpackage

// File: rtl/bcs_catch_ctrl.sv
module bcs_catch_ctrl
  import byte_chain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sync,
  input  logic catch_en,
  output logic take_o,
  output logic held_o
);

  slot_state_t state_q;
  slot_state_t state_d;

  // A marker cycle never captures; the upstream flag may still be stale then.
  assign take_o = in_valid && !in_sync && catch_en && (state_q == SLOT_OPEN);

  always_comb begin
    state_d = state_q;
    if (in_sync) begin
      state_d = SLOT_OPEN;
    end else if (take_o) begin
      state_d = SLOT_HELD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_OPEN;
    end else begin
      state_q <= state_d;
    end
  end

  assign held_o = (state_q == SLOT_HELD);

  // R5: a frame-start leaves the slot open on the next cycle
  a_r5_sync_reopens: assert property (@(posedge clk) disable iff (rst)
    in_sync |=> !held_o);

  // R4: a held slot stays held until a frame-start
  a_r4_held_sticks: assert property (@(posedge clk) disable iff (rst)
    (held_o && !in_sync) |=> held_o);

  // R3: no enable, no change of occupancy
  a_r3_no_enable_stays_open: assert property (@(posedge clk) disable iff (rst)
    (!held_o && !catch_en) |=> !held_o);

endmodule

// File: rtl/bcs_byte_hold.sv
module bcs_byte_hold #(
  parameter int DATA_W = 8,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  localparam int NLANES = (DATA_W + LANE_W - 1) / LANE_W;

  // Register split into lanes so wide data maps onto slice-sized groups
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    localparam int HI = ((LO + LANE_W) > DATA_W) ? DATA_W - 1 : LO + LANE_W - 1;

    always_ff @(posedge clk) begin
      if (rst) begin
        q[HI:LO] <= '0;
      end else if (load) begin
        q[HI:LO] <= d[HI:LO];
      end
    end
  end

  // R8: contents move only when loaded
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/bcs_strobe.sv
module bcs_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
    end
  end

  // R6: single-cycle strobe
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/byte_chain_stage.sv
module byte_chain_stage #(
  parameter int DATA_W = 8,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              catch_en,
  output logic              taken,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid
);

  logic take_w;
  logic held_w;

  bcs_catch_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .catch_en (catch_en),
    .take_o   (take_w),
    .held_o   (held_w)
  );

  bcs_byte_hold #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (take_w),
    .d    (in_byte),
    .q    (out_byte)
  );

  bcs_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .fire    (take_w),
    .pulse_o (out_valid)
  );

  assign taken = held_w;

  // R2: an eligible byte shows up with its strobe one cycle later
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sync && catch_en && !taken) |=>
      (out_valid && taken && out_byte == $past(in_byte)));

  // R4: a stage already holding its byte emits nothing more
  a_r4_no_second: assert property (@(posedge clk) disable iff (rst)
    taken |=> !out_valid);

  // R5: a byte on the marker cycle is dropped
  a_r5_sync_byte_dropped: assert property (@(posedge clk) disable iff (rst)
    in_sync |=> !out_valid);

  // R9: flag rises only together with the strobe
  a_r9_flag_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(taken) |-> out_valid);

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!taken && !out_valid && out_byte == '0));

endmodule

// File: tb/byte_chain_stage_tb_top.sv
module byte_chain_stage_tb_top;

  localparam int NST = 4;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sync = 1'b0;
  logic [DW-1:0] in_byte = '0;
  logic          first_en = 1'b1;

  logic          en_w  [NST];
  logic          got_w [NST];
  logic [DW-1:0] ob_w  [NST];
  logic          ov_w  [NST];

  always #4 clk = ~clk;  // 125 MHz

  for (genvar k = 0; k < NST; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign en_w[k] = first_en;
    end else begin : g_link
      assign en_w[k] = got_w[k-1];
    end
    byte_chain_stage #(.DATA_W(DW)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_sync  (in_sync),
      .in_byte  (in_byte),
      .catch_en (en_w[k]),
      .taken    (got_w[k]),
      .out_byte (ob_w[k]),
      .out_valid(ov_w[k])
    );
  end

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q [$];
  logic        mdl_got [NST];
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; the model of R2/R3/R4/R5/R7 predicts the taker
  task automatic drive(input bit v, input bit s, input logic [DW-1:0] b);
    bit en;
    int taker;
    @(posedge clk); #1;
    in_valid = v; in_sync = s; in_byte = b;
    taker = -1;
    if (s) begin
      for (int k = 0; k < NST; k++) mdl_got[k] = 1'b0;
    end else if (v) begin
      for (int k = 0; k < NST; k++) begin
        en = (k == 0) ? first_en : mdl_got[k-1];
        if (en && !mdl_got[k] && taker < 0) taker = k;
      end
      if (taker >= 0) begin
        mdl_got[taker] = 1'b1;
        exp_q.push_back({8'(taker), b});
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0);
  endtask

  task automatic frame(input int n, input logic [DW-1:0] base, input int gap);
    drive(1'b0, 1'b1, '0);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, base + DW'(i));
      if (gap > 0 && i[0]) idle(gap);
    end
  endtask

  // Monitor / scoreboard (R2, R6, R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < NST; k++) begin
        if (ov_w[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected strobe", k, -1);
          end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(e[15:8] == 8'(k), "R7 stage order", k, int'(e[15:8]));
            chk(ob_w[k] == e[7:0], "R2 captured byte", int'(ob_w[k]), int'(e[7:0]));
          end
        end
      end
    end
  end

  task automatic settle();
    idle(2);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NST; k++) mdl_got[k] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NST; k++) begin
      chk(!got_w[k] && !ov_w[k] && ob_w[k] == '0, "R1 reset state", int'(ob_w[k]), 0);
    end
    @(posedge clk); #1; rst = 1'b0;

    // back-to-back bytes, exact frame length
    frame(4, 8'h11, 0);
    settle();
    for (int k = 0; k < NST; k++) begin
      chk(got_w[k], "R7 all stages taken", int'(got_w[k]), 1);
      chk(ob_w[k] == 8'h11 + DW'(k), "R7 byte per stage", int'(ob_w[k]), 8'h11 + k);
    end

    // gapped and over-long frame: extra bytes ignored
    frame(6, 8'h50, 2);
    settle();
    chk(ob_w[3] == 8'h53, "R4 extra bytes ignored", int'(ob_w[3]), 8'h53);

    // short frame: later stages keep old bytes and stay cleared
    frame(2, 8'hC0, 0);
    settle();
    chk(ob_w[2] == 8'h52, "R8 hold across frame", int'(ob_w[2]), 8'h52);
    chk(!got_w[2] && !got_w[3], "R5 flag cleared by marker", int'(got_w[2]), 0);
    chk(got_w[1], "R7 second stage taken", int'(got_w[1]), 1);

    // byte on the marker cycle is dropped
    drive(1'b1, 1'b1, 8'hEE);
    drive(1'b1, 1'b0, 8'hD1);
    drive(1'b1, 1'b0, 8'hD2);
    settle();
    chk(ob_w[0] == 8'hD1, "R5 marker byte dropped", int'(ob_w[0]), 8'hD1);

    // enable low: nothing taken; raised mid-frame
    first_en = 1'b0;
    drive(1'b0, 1'b1, '0);
    drive(1'b1, 1'b0, 8'hF1);
    drive(1'b1, 1'b0, 8'hF2);
    settle();
    chk(!got_w[0] && ob_w[0] == 8'hD1, "R3 no capture without enable", int'(ob_w[0]), 8'hD1);
    first_en = 1'b1;
    drive(1'b1, 1'b0, 8'hF3);
    settle();
    chk(ob_w[0] == 8'hF3, "R3 capture after enable rises", int'(ob_w[0]), 8'hF3);

    // marker directly after last byte, frames with no gap
    frame(4, 8'h01, 0);
    frame(4, 8'h05, 0);
    frame(3, 8'h21, 0);
    settle();
    chk(ob_w[3] == 8'h08, "R8 last stage holds", int'(ob_w[3]), 8'h08);
    chk(ob_w[2] == 8'h23 && !got_w[3], "R7 stale flag not used", int'(ob_w[2]), 8'h23);

    idle(3);
    chk(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule